// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block sits behind the low-power receiver of a bus transceiver and is active while the transceiver is in its low-power standby state. It receives a digitised "bus is dominant" indication and produces the receive-data level (`rxd_o`) shown to the local controller. A wake-up request, signalled by driving `rxd_o` low, is only issued once the bus has stayed dominant for longer than a programmable filter time, so short glitches never wake the host.

If standby is entered while the bus is already dominant (for example a bus shorted into the dominant state), the block arms a lockout and suppresses every wake-up request until the bus has been seen recessive for a programmable clear time. This prevents a stuck bus from producing a false wake-up. Outside standby the block keeps `rxd_o` high and forgets all filter and lockout state.

The dominant indication is asynchronous to the local clock and passes through a short register chain before it is used. Times are expressed in clock cycles; at 200 MHz a 1.5 to 5 µs window corresponds to 300 to 1000 cycles.

Top module: `stby_wake_filter`

## Requirements
- R1: While `rst` is high and on the first cycles after its release, `rxd_o` is 1.
- R2: In standby with no lockout, `rxd_o` goes to 0 once the synchronised dominant level has been 1 for more than `FILT_CYC` consecutive sampled cycles; a `bus_dom` level held for `FILT_CYC+1` cycles gives a low pulse, one held for `FILT_CYC` cycles gives none.
- R3: A dominant run of at most `FILT_CYC` sampled cycles leaves `rxd_o` at 1, and any recessive cycle restarts the dominant run count from zero.
- R4: Whenever the synchronised bus level is recessive (`bus_dom` = 0, which also stands for an open or undriven bus), `rxd_o` is 1 on the following cycle, so a wake-up request ends once the bus returns recessive.
- R5: When `stby_en` rises while the synchronised bus level is dominant, a lockout is armed and `rxd_o` stays 1 for as long as the lockout holds, however long the bus stays dominant.
- R6: The lockout clears only after the synchronised bus level has been recessive for `CLR_CYC` consecutive cycles during standby; a shorter recessive gap leaves it armed and the run of recessive cycles restarts.
- R7: After the lockout has cleared, a new dominant run longer than the filter time produces a wake-up request as in R2.
- R8: While `stby_en` is 0, `rxd_o` is 1 on the next cycle and the filter count and lockout are cleared, so re-entering standby with a recessive bus leaves no lockout.
- R9: `bus_dom` passes through `SYNC_STAGES` registers (reset to recessive) before it affects the filter, lockout or output; `rxd_o` is itself a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_en | input | 1 | 1 while the transceiver is in low-power standby |
| bus_dom | input | 1 | Asynchronous bus level from the low-power receiver, 1 = dominant |
| rxd_o | output | 1 | Receive-data level, 0 = wake-up request, 1 = recessive |

## Verification
The hardest state to reach is a lockout that is armed and then cleared: the bench must raise `stby_en` while the bus is already dominant, hold it dominant past the filter time to show suppression, insert a recessive gap just shorter than the clear time, and only then give a full clear window before a fresh dominant run. Directed sequences build exactly that, along with dominant runs of exactly `FILT_CYC` and `FILT_CYC+1` cycles at the filter boundary. A long stretch of random run lengths and standby toggles then hits entries during dominant at arbitrary counter phases, and a behavioural model compares `rxd_o` every cycle.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  typedef enum logic {
    LK_IDLE  = 1'b0,
    LK_ARMED = 1'b1
  } lock_state_t;
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/wkf_run_cnt.sv
module wkf_run_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic full
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt <= '0;
    else if (cnt != CW'(LIMIT))
      cnt <= cnt + CW'(1);
  end

  assign full = (cnt == CW'(LIMIT));
endmodule

// File: rtl/wkf_lockout.sv
module wkf_lockout
  import wkf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stby,
  input  logic sdom,
  input  logic rec_full,
  output logic locked
);
  lock_state_t state;
  logic        stby_prev;

  always_ff @(posedge clk) begin
    if (rst) stby_prev <= 1'b0;
    else     stby_prev <= stby;
  end

  always_ff @(posedge clk) begin
    if (rst || !stby)
      state <= LK_IDLE;
    else if (!stby_prev && sdom)
      state <= LK_ARMED;
    else if (state == LK_ARMED && rec_full)
      state <= LK_IDLE;
  end

  assign locked = (state == LK_ARMED);
endmodule

// File: rtl/stby_wake_filter.sv
module stby_wake_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 16,
  parameter int CLR_CYC     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_en,
  input  logic bus_dom,
  output logic rxd_o
);
  logic sync_dom;
  logic dom_full;
  logic rec_full;
  logic lock_q;
  logic rxd_q;

  // R9: bring the asynchronous bus level into the clock domain
  wkf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (bus_dom),
    .d_out(sync_dom)
  );

  // R2, R3: length of the current dominant run in standby
  wkf_run_cnt #(.LIMIT(FILT_CYC)) u_dom_cnt (
    .clk (clk),
    .rst (rst),
    .en  (stby_en && sync_dom),
    .full(dom_full)
  );

  // R6: length of the current recessive run while locked
  wkf_run_cnt #(.LIMIT(CLR_CYC)) u_rec_cnt (
    .clk (clk),
    .rst (rst),
    .en  (stby_en && lock_q && !sync_dom),
    .full(rec_full)
  );

  // R5, R6, R8: lockout for standby entered with a dominant bus
  wkf_lockout u_lock (
    .clk     (clk),
    .rst     (rst),
    .stby    (stby_en),
    .sdom    (sync_dom),
    .rec_full(rec_full),
    .locked  (lock_q)
  );

  // R1, R4, R8: registered receive level
  always_ff @(posedge clk) begin
    if (rst) rxd_q <= 1'b1;
    else     rxd_q <= !(stby_en && sync_dom && dom_full && !lock_q);
  end

  assign rxd_o = rxd_q;
endmodule

// File: rtl/wkf_checker.sv
module wkf_checker (
  input logic clk,
  input logic rst,
  input logic stby_en,
  input logic sync_dom,
  input logic lock_q,
  input logic dom_full,
  input logic rxd_o
);
  // R8
  out_of_stby_high_chk: assert property (@(posedge clk) disable iff (rst)
    !stby_en |=> rxd_o);

  // R8
  out_of_stby_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !stby_en |=> !lock_q);

  // R4
  recessive_high_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_dom |=> rxd_o);

  // R5
  lock_arm_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(stby_en) && sync_dom) |=> lock_q);

  // R5
  locked_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> rxd_o);

  // R2
  wake_needs_filter_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rxd_o) |-> $past(dom_full));
endmodule

bind stby_wake_filter wkf_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .stby_en (stby_en),
  .sync_dom(sync_dom),
  .lock_q  (lock_q),
  .dom_full(dom_full),
  .rxd_o   (rxd_o)
);

// File: tb/sim_stby_wake_filter.sv
`timescale 1ns/1ps
module sim_stby_wake_filter;
  localparam int SYNC = 2;
  localparam int FILT = 16;
  localparam int CLR  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_en = 1'b0;
  logic bus_dom = 1'b0;
  logic rxd_o;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R1";

  stby_wake_filter #(.SYNC_STAGES(SYNC), .FILT_CYC(FILT), .CLR_CYC(CLR)) u0 (
    .clk(clk), .rst(rst), .stby_en(stby_en), .bus_dom(bus_dom), .rxd_o(rxd_o)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: queue delay, integer run lengths
  bit q_bus[$];
  int m_dom_run, m_rec_run;
  bit m_lock, m_prev_stby, m_rxd;
  bit saw_low;

  initial begin
    for (int i = 0; i < SYNC; i++) q_bus.push_back(1'b0);
    m_rxd = 1'b1;
  end

  always @(posedge clk) begin
    bit s, n_lock, n_rxd;
    int n_dom, n_rec;
    if (rst) begin
      for (int i = 0; i < SYNC; i++) q_bus[i] = 1'b0;
      m_dom_run = 0; m_rec_run = 0; m_lock = 0; m_prev_stby = 0; m_rxd = 1;
    end else begin
      s = q_bus[0];
      n_dom = (stby_en && s) ? ((m_dom_run < FILT) ? m_dom_run + 1 : FILT) : 0;
      n_rec = (stby_en && m_lock && !s) ? ((m_rec_run < CLR) ? m_rec_run + 1 : CLR) : 0;
      if (!stby_en) n_lock = 0;
      else if (!m_prev_stby && s) n_lock = 1;
      else if (m_lock && m_rec_run == CLR) n_lock = 0;
      else n_lock = m_lock;
      n_rxd = !(stby_en && s && m_dom_run == FILT && !m_lock);
      m_dom_run = n_dom; m_rec_run = n_rec; m_lock = n_lock;
      m_rxd = n_rxd; m_prev_stby = stby_en;
      void'(q_bus.pop_front());
      q_bus.push_back(bus_dom);
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    n_chk++;
    if (rxd_o !== m_rxd) begin
      n_fail++;
      $display("FAIL %s cycle compare: rxd_o=%b expected=%b at %0t", cur_req, rxd_o, m_rxd, $time);
    end
    if (rxd_o === 1'b0) saw_low = 1'b1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dom(input int n);
    bus_dom = 1'b1; cyc(n);
  endtask

  task automatic rec(input int n);
    bus_dom = 1'b0; cyc(n);
  endtask

  initial begin
    cyc(1);
    check("R1 in reset", rxd_o, 1'b1);
    cyc(3);
    rst = 1'b0;
    cyc(2);
    check("R1 after reset", rxd_o, 1'b1);

    // R2 / R9: long dominant run wakes after sync + filter latency
    cur_req = "R2";
    stby_en = 1'b1; rec(5);
    saw_low = 0;
    dom(SYNC + FILT);
    check("R2 no wake before filter+sync latency", saw_low, 1'b0);
    dom(2);
    check("R2 wake request after filter", rxd_o, 1'b0);
    cur_req = "R4";
    rec(SYNC + 1);
    check("R4 rxd high after bus recessive", rxd_o, 1'b1);

    // R3: short pulses and filter boundary
    cur_req = "R3";
    saw_low = 0;
    dom(10); rec(1); dom(10); rec(1); dom(FILT); rec(6);
    check("R3 short pulses leave rxd high", saw_low, 1'b0);
    cur_req = "R2";
    saw_low = 0;
    dom(FILT + 1); rec(6);
    check("R2 FILT+1 run gives wake pulse", saw_low, 1'b1);

    // R5: enter standby while dominant
    cur_req = "R5";
    stby_en = 1'b0; bus_dom = 1'b1; cyc(5);
    check("R8 rxd high outside standby", rxd_o, 1'b1);
    saw_low = 0;
    stby_en = 1'b1; cyc(60);
    check("R5 lockout suppresses wake", saw_low, 1'b0);

    // R6: short recessive gap keeps lockout
    cur_req = "R6";
    rec(CLR - 2); dom(40);
    check("R6 short gap keeps lockout", saw_low, 1'b0);
    rec(CLR + SYNC + 4);

    // R7: after clear, fresh dominant wakes
    cur_req = "R7";
    dom(SYNC + FILT + 3);
    check("R7 wake after lockout cleared", rxd_o, 1'b0);
    rec(6);

    // R8: leave standby while dominant, re-enter with recessive bus
    cur_req = "R8";
    dom(SYNC + FILT + 3);
    stby_en = 1'b0; cyc(2);
    check("R8 leaving standby releases rxd", rxd_o, 1'b1);
    rec(6); stby_en = 1'b1; cyc(3);
    saw_low = 0;
    dom(SYNC + FILT + 3);
    check("R8 no stale lockout after re-entry", saw_low, 1'b1);
    rec(5);

    // R4: undriven bus reads recessive
    cur_req = "R4";
    bus_dom = 1'b0; cyc(30);
    check("R4 open bus keeps rxd high", rxd_o, 1'b1);

    // random runs and standby toggles, model compared every cycle
    cur_req = "R5";
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 8) == 0) stby_en = ~stby_en;
      bus_dom = $urandom % 2;
      cyc(1 + ($urandom % (FILT + CLR)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule